// File: doc/BRIEF.md
# Event Timer/Counter with Prescaler

This block is a byte-wide, register-mapped timer/counter for a small processor subsystem. It advances either on an internal instruction-cycle strobe or on edges of an external clock pin. The external pin is synchronized to the system clock, and software picks which edge counts. An optional power-of-two prescaler sits between the selected source and the counter. Software cannot read or write the prescaler. Software may set the counter to a narrow (one byte) width or a wide (two byte) width.

The CPU sees the wide count through two byte registers. A read of the low byte takes a snapshot of the current upper byte into a buffer, so a later read of the upper register returns a value that matches the low byte already read. A write of the upper register only fills that buffer. The next low-byte write then loads both halves in one cycle.

When the counter wraps past its maximum it sets a sticky flag. Software clears the flag. A mask bit gates the flag onto the interrupt output.

Top module: `evt_timer`

## Requirements
- R1: After reset, the control register (address 2) reads 0xFF, the upper-byte buffer (address 1) reads 0x00, the interrupt register (address 3) reads 0x00, the counter is zero and `irq` is low.
- R2: Control register layout: bit 0 enables counting, bit 1 selects narrow width, bit 2 selects the external source, bit 3 selects the falling edge (clear means rising), bit 4 bypasses the prescaler, and bits 7:5 hold the ratio code. Interrupt register layout: bit 0 is the flag and bit 1 is the mask enable. Reads are combinational on `bus_addr`.
- R3: With the internal source selected and the prescaler bypassed, the counter advances by one on each qualifying `tick`.
- R4: A low-byte write discards any source event in its own cycle and in the next two `tick` strobes. Counting resumes on the third tick.
- R5: With bit 4 clear, the counter advances once per 2^(code+1) source events, so code 0 gives 1:2 and code 7 gives 1:256.
- R6: A write to address 0 or address 1 clears the prescaler count. It leaves the control register unchanged.
- R7: In external mode the pin passes through two synchronizer flops and then an edge detector. An edge that is present before clock edge k becomes visible in the count after edge k+2. Edges of the other polarity are ignored, and so are `tick` strobes.
- R8: While bit 0 of the control register is clear, the counter holds its value and all registers stay accessible.
- R9: Reading address 0 copies the counter's upper byte into the buffer in that cycle. Reads of address 1 return the buffer.
- R10: A write to address 1 loads only the buffer. A write to address 0 loads {buffer, data} into the counter in one cycle.
- R11: In narrow mode only the low byte advances. A wrap from 0xFF to 0x00 sets the flag, and the upper byte holds.
- R12: In wide mode the flag is set only by a wrap from 0xFFFF to 0x0000. A carry out of the low byte alone does not set it.
- R13: The flag stays set until software writes 0 to bit 0. If a wrap and a clearing write fall in the same cycle, the flag stays set. `irq` equals flag AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Instruction-cycle strobe, one clock wide |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| bus_addr | input | 2 | Register select: 0 low byte, 1 upper buffer, 2 control, 3 interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; its only side effect is the buffer snapshot on address 0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Masked overflow interrupt |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a wrap and a software clear of the flag. The bench raises `tick` on the cycle where the narrow counter is at 0xFF and writes 0 to the flag bit on that same cycle. It then expects the flag and `irq` to remain set.

The second pair is a low-byte read and a carry into the upper byte. The bench reads address 0 in the cycle that carries 0x12FF to 0x1300. It expects the buffer to hold 0x12, which is the upper byte that belongs with the 0xFF just returned.

A third case is a low-byte write that coincides with a tick. There the bench expects the tick to be lost.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   typedef enum logic [1:0] {
      SEL_LO   = 2'd0,
      SEL_HI   = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_IRQ  = 2'd3
   } reg_sel_e;

   // control register bit positions
   localparam int C_RUN    = 0;
   localparam int C_NARROW = 1;
   localparam int C_EXT    = 2;
   localparam int C_FALL   = 3;
   localparam int C_BYP    = 4;
   localparam int C_SEL    = 5;

   // interrupt register bit positions
   localparam int I_FLAG   = 0;
   localparam int I_EN     = 1;

endpackage

// File: rtl/evt_timer_edge.sv
module evt_timer_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic strobe
);

   if (STAGES < 2) begin : g_bad_stages
      $error("evt_timer_edge: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic q;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= g_stg[i-1].q;
         end
      end
   end

   logic sync_w;
   logic prev_q;

   assign sync_w = g_stg[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_w;
   end

   assign strobe = fall_sel ? (prev_q & ~sync_w) : (sync_w & ~prev_q);

endmodule

// File: rtl/evt_timer_psc.sv
module evt_timer_psc #(
   parameter int PSC_W   = 8,
   parameter bit HAS_PSC = 1'b1,
   localparam int SEL_W  = (PSC_W > 1) ? $clog2(PSC_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             evt,
   input  logic             bypass,
   input  logic [SEL_W-1:0] sel,
   output logic             adv
);

   if (HAS_PSC) begin : g_psc
      if (PSC_W != (1 << SEL_W)) begin : g_bad_w
         $error("evt_timer_psc: PSC_W must be a power of two");
      end

      logic [PSC_W-1:0] cnt_q;
      logic [PSC_W-1:0] mask_w;
      logic             hit_w;

      always_comb begin
         for (int j = 0; j < PSC_W; j++) begin
            mask_w[j] = (j <= int'(sel));
         end
      end

      assign hit_w = ((cnt_q & mask_w) == mask_w);
      assign adv   = evt & (bypass | hit_w);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (clr)            cnt_q <= '0;
         else if (evt && !bypass) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_nopsc
      logic unused_w;
      assign unused_w = clr ^ bypass ^ (^sel) ^ clk ^ rst_n;
      assign adv      = evt;
   end

endmodule

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             narrow,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);

   logic [BYTE_W-1:0] lo_w;
   logic [BYTE_W-1:0] hi_w;
   logic              lo_max_w;
   logic              all_max_w;

   assign lo_w      = cnt[BYTE_W-1:0];
   assign hi_w      = cnt[CNT_W-1:BYTE_W];
   assign lo_max_w  = (lo_w == {BYTE_W{1'b1}});
   assign all_max_w = lo_max_w && (hi_w == {BYTE_W{1'b1}});
   assign ovf       = adv && !load && (narrow ? lo_max_w : all_max_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (load)   cnt <= load_val;
      else if (adv) begin
         if (narrow)   cnt <= {hi_w, lo_w + 1'b1};
         else          cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
   parameter int BYTE_W      = 8,
   parameter int PSC_W       = 8,
   parameter bit HAS_PSC     = 1'b1,
   parameter int SYNC_STAGES = 2,
   parameter int INH_TICKS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ext_clk_in,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              irq
);
   import evt_timer_pkg::*;

   localparam int CNT_W = 2 * BYTE_W;
   localparam int SEL_W = (PSC_W > 1) ? $clog2(PSC_W) : 1;
   localparam int INH_W = $clog2(INH_TICKS + 1);

   if (C_SEL + SEL_W > BYTE_W) begin : g_bad_ctrl
      $error("evt_timer: ratio field does not fit the control byte");
   end
   if (INH_TICKS < 1) begin : g_bad_inh
      $error("evt_timer: INH_TICKS must be at least 1");
   end

   reg_sel_e          sel_w;
   logic              wr_lo, wr_hi, wr_ctrl, wr_irq, rd_lo;
   logic [BYTE_W-1:0] ctrl_q;
   logic [BYTE_W-1:0] hibuf_q;
   logic              flag_q, ien_q;
   logic [INH_W-1:0]  inh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              edge_stb, src_evt, qual_evt, adv_w, ovf_w;

   assign sel_w   = reg_sel_e'(bus_addr);
   assign wr_lo   = bus_wr && (sel_w == SEL_LO);
   assign wr_hi   = bus_wr && (sel_w == SEL_HI);
   assign wr_ctrl = bus_wr && (sel_w == SEL_CTRL);
   assign wr_irq  = bus_wr && (sel_w == SEL_IRQ);
   assign rd_lo   = bus_rd && !bus_wr && (sel_w == SEL_LO);

   evt_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_clk_in),
      .fall_sel (ctrl_q[C_FALL]),
      .strobe   (edge_stb)
   );

   assign src_evt  = ctrl_q[C_EXT] ? edge_stb : tick;
   assign qual_evt = ctrl_q[C_RUN] && src_evt && (inh_q == '0) && !wr_lo;

   evt_timer_psc #(.PSC_W(PSC_W), .HAS_PSC(HAS_PSC)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (wr_lo | wr_hi),
      .evt    (qual_evt),
      .bypass (ctrl_q[C_BYP]),
      .sel    (ctrl_q[C_SEL +: SEL_W]),
      .adv    (adv_w)
   );

   evt_timer_cnt #(.BYTE_W(BYTE_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv_w),
      .narrow   (ctrl_q[C_NARROW]),
      .load     (wr_lo),
      .load_val ({hibuf_q, bus_wdata}),
      .cnt      (cnt_q),
      .ovf      (ovf_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     inh_q <= '0;
      else if (wr_lo)                 inh_q <= INH_W'(INH_TICKS);
      else if (tick && inh_q != '0)   inh_q <= inh_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '1;
      else if (wr_ctrl) ctrl_q <= bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hibuf_q <= '0;
      else if (wr_hi) hibuf_q <= bus_wdata;
      else if (rd_lo) hibuf_q <= cnt_q[CNT_W-1:BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         if (ovf_w)       flag_q <= 1'b1;
         else if (wr_irq) flag_q <= bus_wdata[I_FLAG];
         if (wr_irq)      ien_q  <= bus_wdata[I_EN];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel_w)
         SEL_LO:   bus_rdata = cnt_q[BYTE_W-1:0];
         SEL_HI:   bus_rdata = hibuf_q;
         SEL_CTRL: bus_rdata = ctrl_q;
         SEL_IRQ: begin
            bus_rdata[I_FLAG] = flag_q;
            bus_rdata[I_EN]   = ien_q;
         end
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = flag_q & ien_q;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          bus_addr,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [BYTE_W-1:0]   bus_wdata,
   input logic                irq,
   input logic [2*BYTE_W-1:0] cnt_q,
   input logic [BYTE_W-1:0]   hibuf_q,
   input logic [BYTE_W-1:0]   ctrl_q,
   input logic                flag_q,
   input logic                ien_q
);
   import evt_timer_pkg::*;

   localparam int CNT_W = 2 * BYTE_W;

   logic c_wr_lo, c_wr_hi, c_wr_irq, c_rd_lo;
   assign c_wr_lo  = bus_wr && (bus_addr == 2'd0);
   assign c_wr_hi  = bus_wr && (bus_addr == 2'd1);
   assign c_wr_irq = bus_wr && (bus_addr == 2'd3);
   assign c_rd_lo  = bus_rd && !bus_wr && (bus_addr == 2'd0);

   p_lo_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      c_wr_lo |=> cnt_q == {$past(hibuf_q), $past(bus_wdata)});

   p_hi_buf_r10: assert property (@(posedge clk) disable iff (!rst_n)
      c_wr_hi |=> hibuf_q == $past(bus_wdata));

   p_lo_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd_lo |=> hibuf_q == $past(cnt_q[CNT_W-1:BYTE_W]));

   p_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      c_wr_lo ##1 !c_wr_lo |=> $stable(cnt_q));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[C_RUN] && !c_wr_lo |=> $stable(cnt_q));

   p_narrow_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[C_NARROW] && !c_wr_lo |=> cnt_q[CNT_W-1:BYTE_W] == $past(cnt_q[CNT_W-1:BYTE_W]));

   p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !c_wr_irq |=> flag_q);

   p_irq_mask_r13: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ien_q && flag_q);

   p_flag_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) && !$past(c_wr_irq) |->
         $past(cnt_q[BYTE_W-1:0]) == {BYTE_W{1'b1}} && cnt_q[BYTE_W-1:0] == '0);

endmodule

bind evt_timer evt_timer_chk #(.BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       ext_clk_in = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   evt_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ext_clk_in(ext_clk_in),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   task automatic rd_lo(output logic [7:0] d);
      @(negedge clk);
      bus_addr = 2'd0; bus_rd = 1'b1;
      #0.5 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic ext_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_clk_in = 1'b1;
         repeat (4) @(negedge clk);
         ext_clk_in = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      #500us;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      peek(2'd2, v); chk("R1 ctrl reset", v, 8'hFF);
      peek(2'd1, v); chk("R1 hi buffer reset", v, 8'h00);
      peek(2'd3, v); chk("R1 irq reg reset", v, 8'h00);
      peek(2'd0, v); chk("R1 counter reset", v, 8'h00);
      chk("R1 irq low", irq, 0);

      // R2 control written back; R3/R4 timer sweep, wide, bypass
      wr(2'd2, 8'h11);
      peek(2'd2, v); chk("R2 ctrl readback", v, 8'h11);
      for (int n = 0; n < 7; n++) begin
         wr(2'd1, 8'h00);
         wr(2'd0, 8'h00);
         ticks(n);
         peek(2'd0, v);
         chk("R4 R3 inhibit sweep", v, (n > 2) ? n - 2 : 0);
      end

      // R4 tick in the same cycle as a low write is lost
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 8'h10; bus_wr = 1'b1; tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick = 1'b0;
      ticks(2);
      peek(2'd0, v); chk("R4 write-cycle tick", v, 8'h10);
      ticks(1);
      peek(2'd0, v); chk("R4 third tick counts", v, 8'h11);

      // R5 prescaler ratio sweep
      for (int s = 0; s < 8; s++) begin
         int ratio;
         ratio = 2 << s;
         wr(2'd2, 8'(1 | (s << 5)));
         wr(2'd1, 8'h00);
         wr(2'd0, 8'h00);
         ticks(2 + 3 * ratio - 1);
         peek(2'd0, v); chk("R5 prescale before edge", v, 2);
         ticks(1);
         peek(2'd0, v); chk("R5 prescale after edge", v, 3);
      end

      // R6 a high write clears the prescaler, ratio kept
      wr(2'd2, 8'h21);
      wr(2'd0, 8'h00);
      ticks(5);
      wr(2'd1, 8'h00);
      ticks(3);
      peek(2'd0, v); chk("R6 prescaler cleared", v, 0);
      ticks(1);
      peek(2'd0, v); chk("R6 ratio kept", v, 1);
      peek(2'd2, v); chk("R6 ctrl unchanged", v, 8'h21);

      // R9/R10/R12 wide atomic access
      wr(2'd2, 8'h11);
      wr(2'd3, 8'h00);
      wr(2'd1, 8'h12);
      wr(2'd0, 8'hFD);
      ticks(7);
      peek(2'd1, v); chk("R9 stale buffer before low read", v, 8'h12);
      rd_lo(v); chk("R10 low after load", v, 8'h02);
      peek(2'd1, v); chk("R9 snapshot high", v, 8'h13);
      peek(2'd3, v); chk("R12 low carry no flag", v, 8'h00);

      // R9 low read colliding with carry into upper byte
      wr(2'd1, 8'h12);
      wr(2'd0, 8'hFE);
      ticks(3);
      @(negedge clk);
      bus_addr = 2'd0; bus_rd = 1'b1; tick = 1'b1;
      #0.5 v = bus_rdata;
      chk("R9 read value at carry", v, 8'hFF);
      @(negedge clk);
      bus_rd = 1'b0; tick = 1'b0;
      peek(2'd1, v); chk("R9 buffer holds pre-carry high", v, 8'h12);
      peek(2'd0, v); chk("R3 low after carry", v, 8'h00);

      // R12/R13 wide overflow and masking
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'hFE);
      ticks(3);
      peek(2'd3, v); chk("R12 no flag at FFFF", v, 8'h00);
      ticks(1);
      peek(2'd3, v); chk("R12 flag on wide wrap", v, 8'h01);
      chk("R13 irq masked", irq, 0);
      wr(2'd3, 8'h03);
      chk("R13 irq enabled", irq, 1);
      ticks(3);
      peek(2'd3, v); chk("R13 flag sticky", v, 8'h03);
      wr(2'd3, 8'h02);
      chk("R13 irq after clear", irq, 0);

      // R11 narrow mode
      wr(2'd2, 8'h13);
      wr(2'd1, 8'h40);
      wr(2'd0, 8'hFE);
      ticks(4);
      rd_lo(v); chk("R11 low wrapped", v, 8'h00);
      peek(2'd1, v); chk("R11 upper held", v, 8'h40);
      peek(2'd3, v); chk("R11 narrow flag", v, 8'h03);

      // R13 wrap and clear in the same cycle: set wins
      wr(2'd0, 8'hFE);
      ticks(3);
      @(negedge clk);
      bus_addr = 2'd3; bus_wdata = 8'h02; bus_wr = 1'b1; tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick = 1'b0;
      peek(2'd3, v); chk("R13 set beats clear", v, 8'h03);
      chk("R13 irq stays", irq, 1);
      wr(2'd3, 8'h00);

      // R8 run bit clear holds count
      wr(2'd2, 8'h10);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h05);
      ticks(6);
      peek(2'd0, v); chk("R8 hold while stopped", v, 8'h05);

      // R7 external rising edge with latency
      wr(2'd2, 8'h15);
      wr(2'd0, 8'h00);
      ticks(2);
      @(negedge clk); ext_clk_in = 1'b1;
      @(posedge clk); @(posedge clk);
      #1 bus_addr = 2'd0;
      #0.5 chk("R7 not yet after two edges", bus_rdata, 0);
      @(posedge clk);
      #1.5 chk("R7 counted after third edge", bus_rdata, 1);
      @(negedge clk); ext_clk_in = 1'b0;
      repeat (5) @(negedge clk);
      peek(2'd0, v); chk("R7 falling ignored in rising mode", v, 1);
      ext_pulses(3);
      peek(2'd0, v); chk("R7 rising pulses", v, 4);
      ticks(5);
      peek(2'd0, v); chk("R7 ticks ignored", v, 4);

      // R7 external falling edge
      wr(2'd2, 8'h1D);
      wr(2'd0, 8'h00);
      ticks(2);
      ext_pulses(3);
      peek(2'd0, v); chk("R7 falling pulses", v, 3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule